// File: doc/BRIEF.md
# SPI Master with Block-Mode Framing

This block is a serial peripheral interface master. Words written through a valid/ready port go into a transmit FIFO. The shift engine takes them one at a time and shifts each out most significant bit first. For every word sent, one received word goes into a receive FIFO, read back through a second valid/ready port. The word length runs from 1 to 16 bits, and received words are right-aligned. The serial clock comes from a two-factor divider of the system clock, and any of the four polarity/phase combinations can be used.

Eight active-low chip-select lines are provided, and a 3-bit field picks the one that is driven. A disable input keeps all of them high, so that external decoders can handle selection. Outside block mode, chip select goes high after every word. In block mode it stays low across back-to-back words until a word tagged as the last of its frame has gone out, or until the transmit FIFO runs dry. A pause input lets software fill the transmit FIFO before any shifting begins. A loopback input sends the outgoing bit stream straight back into the receive path.

Configuration inputs are meant to change only while the engine is idle or disabled. Dropping the enable input lets the word in flight finish and then releases chip select.

Top module: `spi_blk_master`

## Requirements
- R1: After reset, all chip-select lines are high, `sck` equals `cpol`, `mosi` is 0, `tx_empty` and `tx_not_full` are 1, and `rx_not_empty` and `rx_overrun` are 0.
- R2: `wsize` holds the bit count minus one (7 means 8 bits, 3 means 4, 15 means 16, 0 means 1). Only the low `wsize+1` bits of a transmit word are sent, most significant first. The received word is right-aligned with zeros above it.
- R3: The `sck` period is `max(prescale,2) * (scrdv+1)` system clocks. A `prescale` of 0 or 1 behaves like 2.
- R4: `sck` rests at `cpol` between words. With `cpha`=0 it is still at `cpol` in the first cycle that chip select is low. With `cpha`=1 it has already moved to the opposite level in that cycle. Each word has exactly `wsize+1` leading edges.
- R5: At most one chip-select line is low at a time, and it is the line numbered `cs_sel` (bit 5 for `cs_sel`=5). While `sod` is 1, every line stays high and data still moves.
- R6: With `blk_mode`=0, chip select goes high between any two words, so N words give N chip-select falling edges.
- R7: With `blk_mode`=1, chip select stays low across consecutive words. The frame ends after a word pushed with `tx_last`=1, or when the transmit FIFO is empty at the end of a word.
- R8: While `tx_pause` is 1, words are accepted into the transmit FIFO but no shifting and no chip-select activity take place. Clearing `tx_pause` starts transmission.
- R9: `tx_not_full` and `tx_ready` drop after 16 words are buffered, and `tx_empty` shows an empty transmit FIFO. A one-cycle `clr_tx` empties the transmit FIFO, and a one-cycle `clr_rx` empties the receive FIFO.
- R10: With `loopback`=1 the received word equals the sent word and `miso` is ignored. With `loopback`=0 the bits come from `miso`.
- R11: The receive FIFO holds 16 words. A word that completes while it is full is dropped and sets `rx_overrun`. The flag stays set until `clr_rx`.
- R12: Clearing `en` lets the current word finish, then releases chip select. Words not yet started stay in the transmit FIFO and go out once `en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase: 1 moves data on the leading edge |
| loopback | input | 1 | Route outgoing bits into the receive path |
| sod | input | 1 | Keep all chip selects high |
| blk_mode | input | 1 | Hold chip select across consecutive words |
| tx_pause | input | 1 | Hold off shifting while the FIFO is filled |
| wsize | input | 4 | Word bit count minus one |
| cs_sel | input | 3 | Index of the chip select to drive |
| prescale | input | 8 | First divider factor (minimum 2) |
| scrdv | input | 4 | Second divider factor minus one |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 16 | Transmit word (low bits used) |
| tx_last | input | 1 | Word ends a block-mode frame |
| tx_ready | output | 1 | Transmit FIFO can accept a word |
| rx_valid | output | 1 | Received word available |
| rx_data | output | 16 | Received word, right-aligned |
| rx_ready | input | 1 | Consumer takes the received word |
| clr_rx | input | 1 | Empty receive FIFO, clear overrun |
| clr_tx | input | 1 | Empty transmit FIFO |
| tx_not_full | output | 1 | Transmit FIFO has space |
| tx_empty | output | 1 | Transmit FIFO is empty |
| rx_not_empty | output | 1 | Receive FIFO holds data |
| rx_overrun | output | 1 | A received word was dropped |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
Loopback transfers at word lengths of 1, 4, 8 and 16 bits show whether the length field is honoured, whether upper bits are masked, and whether the order is most significant bit first. That order is confirmed separately by recording `mosi` at each leading edge. All four clock modes are tried, and the `sck` level at the first low cycle of chip select tells the two phases apart. Divider settings with even, odd and clamped products are separated by measuring the spacing of leading edges. Runs of several words are sent with block mode off, with block mode on plus a stop tag, and with pause, disable, overrun and an external `miso` slave. Together these separate the framing rules, the FIFO limits and the choice of input source.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } spim_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          wr, rd;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign wr    = push && !full;
  assign rd    = pop && !empty;
  assign rdata = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr) wp <= bump(wp);
      if (rd) rp <= bump(rp);
      case ({wr, rd})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full); // R11
  AST_FIFO_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty); // R9
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 4,
  localparam int PW   = PRE_W + DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  input  logic [DIV_W-1:0] scrdv,
  output logic             half_hit,
  output logic             end_hit,
  output logic             first_half
);
  logic [PRE_W-1:0] eff_pre;
  logic [PW-1:0]    period, half, cnt;

  assign eff_pre    = (prescale < PRE_W'(2)) ? PRE_W'(2) : prescale;
  assign period     = PW'(eff_pre) * (PW'(scrdv) + PW'(1));
  assign half       = period >> 1;
  assign half_hit   = run && (cnt == half);
  assign end_hit    = run && (cnt == period - PW'(1));
  assign first_half = (cnt < half);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (end_hit) cnt <= '0;
    else              cnt <= cnt + PW'(1);
  end

  AST_DIV_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < period)); // R3
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NCS  = 8,
  localparam int SW  = $clog2(DW),
  localparam int CSW = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           tx_pause,
  input  logic           blk_mode,
  input  logic           cpol,
  input  logic           cpha,
  input  logic           loopback,
  input  logic           sod,
  input  logic [SW-1:0]  wsize,
  input  logic [CSW-1:0] cs_sel,
  input  logic           tx_avail,
  input  logic [DW-1:0]  tx_word,
  input  logic           tx_stop,
  output logic           tx_pop,
  input  logic           miso,
  input  logic           half_hit,
  input  logic           end_hit,
  input  logic           first_half,
  output logic           run,
  output logic           rx_push,
  output logic [DW-1:0]  rx_word,
  output logic           sck,
  output logic           mosi,
  output logic [NCS-1:0] cs_n
);
  spim_state_e    state;
  logic [DW-1:0]  sh, rx_sh, rx_next, load_val;
  logic [SW-1:0]  bitcnt;
  logic           stop_q, cs_act;
  logic           can_go, last_bit, cont, in_bit;
  logic [NCS-1:0] cs_n_d;

  assign can_go   = en && !tx_pause && tx_avail;
  assign last_bit = (bitcnt == wsize);
  assign cont     = blk_mode && !stop_q && can_go;
  assign in_bit   = loopback ? sh[DW-1] : miso;
  assign rx_next  = half_hit ? {rx_sh[DW-2:0], in_bit} : rx_sh;
  assign load_val = tx_word << (SW'(DW - 1) - wsize);
  assign run      = (state == ST_SHIFT);
  assign rx_push  = run && end_hit && last_bit;
  assign rx_word  = rx_next;
  assign tx_pop   = ((state == ST_IDLE) && can_go) || (rx_push && cont);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sh     <= '0;
      rx_sh  <= '0;
      bitcnt <= '0;
      stop_q <= 1'b0;
      cs_act <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cs_act <= 1'b0;
          if (can_go) begin
            sh     <= load_val;
            rx_sh  <= '0;
            bitcnt <= '0;
            stop_q <= tx_stop;
            cs_act <= 1'b1;
            state  <= ST_SHIFT;
          end
        end
        default: begin
          rx_sh <= rx_next;
          if (end_hit) begin
            if (last_bit) begin
              if (cont) begin
                sh     <= load_val;
                rx_sh  <= '0;
                bitcnt <= '0;
                stop_q <= tx_stop;
              end else begin
                cs_act <= 1'b0;
                state  <= ST_IDLE;
              end
            end else begin
              bitcnt <= bitcnt + SW'(1);
              sh     <= {sh[DW-2:0], 1'b0};
            end
          end
        end
      endcase
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n_d[i] = !(cs_act && !sod && (cs_sel == CSW'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck  <= cpol;
      mosi <= 1'b0;
      cs_n <= '1;
    end else begin
      sck  <= cpol ^ (run && (cpha ? first_half : !first_half));
      mosi <= run ? sh[DW-1] : 1'b0;
      cs_n <= cs_n_d;
    end
  end

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && tx_pause) |=> (state == ST_IDLE)); // R8
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ($past(state == ST_IDLE) && $stable(cpol)) |-> (sck == cpol)); // R4
  AST_BIT_IN_WORD: assert property (@(posedge clk) disable iff (rst)
    run |-> (bitcnt <= wsize)); // R2
endmodule

// File: rtl/spi_blk_master.sv
module spi_blk_master #(
  parameter int DW     = 16,
  parameter int FDEPTH = 16,
  parameter int PRE_W  = 8,
  parameter int DIV_W  = 4,
  parameter int NCS    = 8,
  localparam int SW    = $clog2(DW),
  localparam int CSW   = $clog2(NCS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             loopback,
  input  logic             sod,
  input  logic             blk_mode,
  input  logic             tx_pause,
  input  logic [SW-1:0]    wsize,
  input  logic [CSW-1:0]   cs_sel,
  input  logic [PRE_W-1:0] prescale,
  input  logic [DIV_W-1:0] scrdv,
  input  logic             tx_valid,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_last,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [DW-1:0]    rx_data,
  input  logic             rx_ready,
  input  logic             clr_rx,
  input  logic             clr_tx,
  output logic             tx_not_full,
  output logic             tx_empty,
  output logic             rx_not_empty,
  output logic             rx_overrun,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NCS-1:0]   cs_n
);
  logic [DW:0]   txq_out;
  logic          txq_empty, txq_full, tx_pop;
  logic          rxq_empty, rxq_full, rx_push;
  logic [DW-1:0] rx_word;
  logic          run, half_hit, end_hit, first_half;
  logic          ovr_q;

  spim_fifo #(.W(DW + 1), .DEPTH(FDEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(clr_tx),
    .push(tx_valid), .wdata({tx_last, tx_data}),
    .pop(tx_pop), .rdata(txq_out),
    .empty(txq_empty), .full(txq_full)
  );

  spim_fifo #(.W(DW), .DEPTH(FDEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(clr_rx),
    .push(rx_push), .wdata(rx_word),
    .pop(rx_ready), .rdata(rx_data),
    .empty(rxq_empty), .full(rxq_full)
  );

  spim_clkdiv #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(run),
    .prescale(prescale), .scrdv(scrdv),
    .half_hit(half_hit), .end_hit(end_hit), .first_half(first_half)
  );

  spim_engine #(.DW(DW), .NCS(NCS)) u_eng (
    .clk(clk), .rst(rst), .en(en), .tx_pause(tx_pause), .blk_mode(blk_mode),
    .cpol(cpol), .cpha(cpha), .loopback(loopback), .sod(sod),
    .wsize(wsize), .cs_sel(cs_sel),
    .tx_avail(!txq_empty), .tx_word(txq_out[DW-1:0]), .tx_stop(txq_out[DW]),
    .tx_pop(tx_pop), .miso(miso),
    .half_hit(half_hit), .end_hit(end_hit), .first_half(first_half),
    .run(run), .rx_push(rx_push), .rx_word(rx_word),
    .sck(sck), .mosi(mosi), .cs_n(cs_n)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_rx)          ovr_q <= 1'b0;
    else if (rx_push && rxq_full) ovr_q <= 1'b1;
  end

  assign tx_ready     = !txq_full;
  assign tx_not_full  = !txq_full;
  assign tx_empty     = txq_empty;
  assign rx_valid     = !rxq_empty;
  assign rx_not_empty = !rxq_empty;
  assign rx_overrun   = ovr_q;

  AST_CS_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1); // R5
  AST_SOD_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
    (sod && $past(sod)) |-> (&cs_n)); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !clr_rx) |=> rx_overrun); // R11
endmodule

// File: tb/spi_blk_master_tb_top.sv
`timescale 1ns/1ps
module spi_blk_master_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic en, cpol, cpha, loopback, sod, blk_mode, tx_pause;
  logic [3:0] wsize;
  logic [2:0] cs_sel;
  logic [7:0] prescale;
  logic [3:0] scrdv;
  logic tx_valid, tx_last, tx_ready, rx_valid, rx_ready, clr_rx, clr_tx;
  logic [15:0] tx_data, rx_data;
  logic tx_not_full, tx_empty, rx_not_empty, rx_overrun;
  logic sck, mosi, miso;
  logic [7:0] cs_n;

  spi_blk_master dut_i (
    .clk(clk), .rst(rst), .en(en), .cpol(cpol), .cpha(cpha), .loopback(loopback),
    .sod(sod), .blk_mode(blk_mode), .tx_pause(tx_pause), .wsize(wsize), .cs_sel(cs_sel),
    .prescale(prescale), .scrdv(scrdv), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .clr_rx(clr_rx), .clr_tx(clr_tx), .tx_not_full(tx_not_full),
    .tx_empty(tx_empty), .rx_not_empty(rx_not_empty), .rx_overrun(rx_overrun),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;

  // monitor state
  int lead_cnt, cs_fall_cnt, last_lead, lead_gap, qcnt;
  logic [15:0] mosi_word;
  logic [7:0] cs_seen, prev_cs;
  logic prev_sck, fall_sck;
  // slave model (mode 0 only)
  bit sl_on = 0;
  logic [15:0] sl_word;
  int sl_n = 8, sl_k;

  task automatic report;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: run did not end, actual=%0d expected<150000", cyc);
      report();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (sck !== prev_sck) begin
        qcnt = 0;
        if (sck !== cpol) begin
          lead_cnt++;
          mosi_word = {mosi_word[14:0], mosi};
          lead_gap = cyc - last_lead;
          last_lead = cyc;
        end else if (sl_on && !(&cs_n) && sl_k >= 0) begin
          miso = sl_word[sl_k];
          sl_k--;
        end
      end else if (&cs_n) qcnt++;
      else qcnt = 0;
      if ((&prev_cs) && !(&cs_n)) begin
        cs_fall_cnt++;
        fall_sck = sck;
        if (sl_on) begin
          miso = sl_word[sl_n-1];
          sl_k = sl_n - 2;
        end
      end
      cs_seen |= ~cs_n;
    end
    prev_sck = sck;
    prev_cs = cs_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon;
    lead_cnt = 0; cs_fall_cnt = 0; cs_seen = 0; mosi_word = 0; lead_gap = 0;
  endtask

  task automatic defaults;
    en = 1; cpol = 0; cpha = 0; loopback = 1; sod = 0; blk_mode = 0; tx_pause = 0;
    wsize = 4'd7; cs_sel = 3'd0; prescale = 8'd2; scrdv = 4'd0;
  endtask

  task automatic push(input logic [15:0] d, input logic last);
    @(negedge clk);
    tx_valid = 1; tx_data = d; tx_last = last;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0; tx_last = 0;
  endtask

  task automatic pop_exp(input logic [15:0] exp, input string req);
    int n = 0;
    @(negedge clk);
    while (!rx_valid && n < 200) begin @(negedge clk); n++; end
    chk(rx_valid && rx_data == exp, req, int'(rx_data), int'(exp));
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
  endtask

  task automatic wait_quiet;
    repeat (4) @(negedge clk);
    while (qcnt < 40) @(negedge clk);
  endtask

  task automatic strobe_rx;
    @(negedge clk); clr_rx = 1; @(negedge clk); clr_rx = 0;
  endtask

  task automatic t_reset;
    chk(cs_n == 8'hFF, "R1 cs_n", cs_n, 8'hFF);
    chk(sck == cpol && mosi == 0, "R1 sck/mosi", {sck, mosi}, {cpol, 1'b0});
    chk(tx_empty && tx_not_full, "R1 tx flags", {tx_empty, tx_not_full}, 2'b11);
    chk(!rx_not_empty && !rx_overrun, "R1 rx flags", {rx_not_empty, rx_overrun}, 0);
  endtask

  task automatic one_word(input logic [3:0] ws, input logic [15:0] d, input logic [15:0] exp,
                          input string req);
    wsize = ws;
    clr_mon();
    push(d, 0);
    wait_quiet();
    chk(lead_cnt == int'(ws) + 1, {req, " edges"}, lead_cnt, int'(ws) + 1);
    pop_exp(exp, req);
  endtask

  task automatic t_sizes;
    defaults();
    one_word(4'd7, 16'h00A5, 16'h00A5, "R2 8b R10");
    chk(mosi_word == 16'h00A5, "R2 msb first", mosi_word, 16'h00A5);
    one_word(4'd3, 16'hFFF6, 16'h0006, "R2 4b");
    one_word(4'd15, 16'hBEEF, 16'hBEEF, "R2 16b");
    one_word(4'd0, 16'h0003, 16'h0001, "R2 1b");
    wsize = 4'd7;
  endtask

  task automatic div_case(input logic [7:0] p, input logic [3:0] s, input int exp);
    prescale = p; scrdv = s;
    clr_mon();
    push(16'h0055, 0);
    wait_quiet();
    chk(lead_gap == exp, "R3 sck period", lead_gap, exp);
    pop_exp(16'h0055, "R3 data");
  endtask

  task automatic t_div;
    defaults();
    div_case(8'd3, 4'd1, 6);
    div_case(8'd5, 4'd2, 15);
    div_case(8'd0, 4'd0, 2);
    div_case(8'd1, 4'd0, 2);
  endtask

  task automatic t_modes;
    defaults();
    prescale = 8'd4;
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0];
      repeat (3) @(negedge clk);
      chk(sck == cpol, "R4 idle level", sck, cpol);
      clr_mon();
      push(16'h00C3, 0);
      wait_quiet();
      chk(fall_sck == (cpol ^ cpha), "R4 phase at select", fall_sck, cpol ^ cpha);
      chk(lead_cnt == 8, "R4 edge count", lead_cnt, 8);
      chk(sck == cpol, "R4 back to idle", sck, cpol);
      pop_exp(16'h00C3, "R4 data");
    end
  endtask

  task automatic t_select;
    defaults();
    cs_sel = 3'd5;
    clr_mon();
    push(16'h0012, 0);
    wait_quiet();
    chk(cs_seen == 8'h20, "R5 line 5", cs_seen, 8'h20);
    pop_exp(16'h0012, "R5 data");
    sod = 1;
    clr_mon();
    push(16'h0034, 0);
    wait_quiet();
    chk(cs_seen == 8'h00 && lead_cnt == 8, "R5 sod quiet", cs_seen, 0);
    pop_exp(16'h0034, "R5 sod data");
  endtask

  task automatic t_nonblock;
    defaults();
    tx_pause = 1;
    clr_mon();
    push(16'h0001, 0); push(16'h0002, 0); push(16'h0003, 0);
    @(negedge clk); tx_pause = 0;
    wait_quiet();
    chk(cs_fall_cnt == 3, "R6 frames", cs_fall_cnt, 3);
    for (int i = 1; i <= 3; i++) pop_exp(16'(i), "R6 data");
  endtask

  task automatic t_block;
    defaults();
    blk_mode = 1; tx_pause = 1;
    clr_mon();
    push(16'h0011, 0); push(16'h0022, 1); push(16'h0033, 0); push(16'h0044, 0);
    @(negedge clk); tx_pause = 0;
    wait_quiet();
    chk(cs_fall_cnt == 2, "R7 frames", cs_fall_cnt, 2);
    chk(lead_cnt == 32, "R7 edges", lead_cnt, 32);
    pop_exp(16'h0011, "R7 d0"); pop_exp(16'h0022, "R7 d1");
    pop_exp(16'h0033, "R7 d2"); pop_exp(16'h0044, "R7 d3");
  endtask

  task automatic t_pause;
    defaults();
    tx_pause = 1;
    clr_mon();
    for (int i = 0; i < 16; i++) push(16'(i), 0);
    chk(!tx_not_full && !tx_ready, "R9 full", {tx_not_full, tx_ready}, 0);
    repeat (30) @(negedge clk);
    chk(lead_cnt == 0 && cs_fall_cnt == 0, "R8 paused", lead_cnt, 0);
    @(negedge clk); clr_tx = 1; @(negedge clk); clr_tx = 0;
    chk(tx_empty && tx_not_full, "R9 clr_tx", tx_empty, 1);
    tx_pause = 0;
    wait_quiet();
    chk(lead_cnt == 0, "R9 cleared words not sent", lead_cnt, 0);
  endtask

  task automatic t_overrun;
    defaults();
    tx_pause = 1;
    clr_mon();
    for (int i = 0; i < 16; i++) push(16'(i * 7 + 1), 0);
    @(negedge clk); tx_pause = 0;
    wait_quiet();
    chk(lead_cnt == 128, "R8 release starts", lead_cnt, 128);
    chk(rx_not_empty && !rx_overrun, "R11 full no ovr", rx_overrun, 0);
    push(16'h00EE, 0);
    wait_quiet();
    chk(rx_overrun, "R11 overrun set", rx_overrun, 1);
    for (int i = 0; i < 16; i++) pop_exp(16'(i * 7 + 1), "R11 kept");
    chk(!rx_not_empty, "R11 dropped", rx_not_empty, 0);
    chk(rx_overrun, "R11 sticky", rx_overrun, 1);
    push(16'h0077, 0);
    wait_quiet();
    strobe_rx();
    chk(!rx_overrun && !rx_not_empty, "R9 clr_rx", {rx_overrun, rx_not_empty}, 0);
  endtask

  task automatic t_miso;
    defaults();
    loopback = 0; sl_on = 1; sl_word = 16'h003C; sl_n = 8;
    clr_mon();
    push(16'h0081, 0);
    wait_quiet();
    pop_exp(16'h003C, "R10 from miso");
    loopback = 1;
    push(16'h005A, 0);
    wait_quiet();
    pop_exp(16'h005A, "R10 miso ignored");
    sl_on = 0;
  endtask

  task automatic t_enable;
    int n = 0;
    defaults();
    tx_pause = 1;
    clr_mon();
    push(16'h00A1, 0); push(16'h00A2, 0); push(16'h00A3, 0);
    @(negedge clk); tx_pause = 0;
    while (cs_fall_cnt == 0 && n < 100) begin @(negedge clk); n++; end
    en = 0;
    wait_quiet();
    chk(cs_fall_cnt == 1 && lead_cnt == 8, "R12 word finished", lead_cnt, 8);
    chk(&cs_n && !tx_empty, "R12 rest kept", {cs_n, tx_empty}, 9'h1FE);
    pop_exp(16'h00A1, "R12 d0");
    en = 1;
    wait_quiet();
    pop_exp(16'h00A2, "R12 d1");
    pop_exp(16'h00A3, "R12 d2");
  endtask

  initial begin
    defaults();
    tx_valid = 0; tx_data = 0; tx_last = 0; rx_ready = 0; clr_rx = 0; clr_tx = 0;
    miso = 0;
    clr_mon();
    prev_sck = 0; prev_cs = 8'hFF; fall_sck = 0; last_lead = 0; qcnt = 0; sl_k = 0;
    sl_word = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_div();
    t_modes();
    t_select();
    t_nonblock();
    t_block();
    t_pause();
    t_overrun();
    t_miso();
    t_enable();
    done = 1;
    report();
    $finish;
  end
endmodule